// File: doc/BRIEF.md
# Break-Tolerant Asynchronous Serial Receiver

This block receives asynchronous serial frames and times each one from a basic-clock enable, `tick16`, that pulses sixteen times per bit period. The serial line first passes through a two-flop synchronizer. While the receiver is idle, the first tick that sees the synchronized line low counts as the start of a frame, and a phase counter is cleared on that tick. The first bit is sampled on the eighth tick after detection. Every later bit is sampled sixteen ticks after the one before it. Each frame carries a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

A completed byte goes into a holding register, and a full flag is raised. Software reads the byte and pulses `rd_strobe`. Framing, parity and overrun errors set sticky flags, and only a pulse on `clr_err` resets them. A break is a line held low. The receiver does not treat it as a special case: it keeps assembling frames of zeros that fail the stop-bit check. A framing flag cleared during a break therefore sets again. The synchronized line level is available as an output, so software can confirm a break once a framing error has appeared.

Top module: `serial_rx_brk`

## Requirements
- R1: In idle with `rx_en` high, a tick that sees the synchronized line low starts a frame. If the line is high at the mid-start sample (8 ticks later), the frame is abandoned and no byte is produced.
- R2: The first sample falls on the 8th tick after start detection, and each following sample comes 16 ticks after the previous one. Clock cycles without `tick16` do not advance reception, so any tick spacing works.
- R3: The 8 data bits arrive least significant first. At the stop-bit sample, the byte is written to `rx_data` and `rx_full` rises one clock later.
- R4: A stop bit sampled as 0 sets `err_frame`. The byte is still stored.
- R5: `par_mode` selects the parity: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. When parity is enabled, one parity bit follows the data. The XOR of the data and parity bits must be 0 for even parity and 1 for odd parity, otherwise `err_parity` sets. With parity off, `err_parity` never sets.
- R6: A one-cycle `rd_strobe` clears `rx_full` on the next clock edge, unless a byte completes in the same cycle.
- R7: If a byte completes while `rx_full` is set and no `rd_strobe` is present, `err_overrun` sets and `rx_data` keeps the earlier byte.
- R8: The three error flags are sticky. A `clr_err` pulse clears them, but a new error in the same cycle wins. Lowering `rx_en` leaves them unchanged.
- R9: A held-low line produces back-to-back frames of 0x00 with framing errors. A `err_frame` cleared during the break sets again. With odd parity, `err_parity` also sets.
- R10: `rxd_level` shows `rxd` after the two-stage synchronizer, which is two clocks late, and resets to 1.
- R11: While `rx_en` is low, the receiver is held idle and any partial frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Basic-clock enable, 16 pulses per bit |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial input line, idle high |
| par_mode | input | 2 | Parity select (none/even/odd) |
| rd_strobe | input | 1 | Byte read pulse, clears the full flag |
| clr_err | input | 1 | Error-flag clear pulse |
| rx_data | output | 8 | Last stored byte |
| rx_full | output | 1 | A byte is waiting to be read |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| rxd_level | output | 1 | Synchronized line level |

## Verification
A change on `rxd` reaches the receive logic two clocks later. The first sample is taken on the eighth tick after detection, and each stored byte and each flag change appears one clock after the tick carrying the stop-bit sample. The bench model uses its own tick count and copies that latency: it steps at every rising edge on the same input values as the design, and the outputs are compared at the next falling edge. Directed checks run only after a frame has fully ended, or one falling edge after a strobe, so each result is already due when it is checked.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  // Parity bit present on the line for this mode.
  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

  // Error decision from the XOR of data and received parity bit.
  function automatic logic parity_fail(input logic [1:0] mode, input logic xsum);
    case (mode)
      PM_EVEN: return xsum;
      PM_ODD:  return ~xsum;
      default: return 1'b0;
    endcase
  endfunction

  // Sticky flag: a set beats a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= INIT;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= INIT;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/srx_phase.sv
module srx_phase #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic mid_evt
);

  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (tick && run)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign mid_evt = tick && run && (cnt == MID);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          line,
  input  logic          mid_evt,
  input  logic [1:0]    par_mode,
  output logic          start_det,
  output logic          busy,
  output logic          frame_done,
  output logic          stop_bad,
  output logic          parity_bad,
  output logic [DW-1:0] word
);

  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

  rx_state_e     state;
  logic [IW-1:0] idx;
  logic [DW-1:0] shreg;
  logic          pbit;

  assign busy       = (state != ST_IDLE);
  assign start_det  = en && tick && (state == ST_IDLE) && !line;
  assign frame_done = mid_evt && (state == ST_STOP);
  assign stop_bad   = !line;
  assign parity_bad = parity_fail(par_mode, ^{shreg, pbit});
  assign word       = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
    end else if (start_det) begin
      state <= ST_START;
    end else if (mid_evt) begin
      case (state)
        ST_START: begin
          state <= line ? ST_IDLE : ST_DATA;
          idx   <= '0;
          pbit  <= 1'b0;
        end
        ST_DATA: begin
          shreg <= {line, shreg[DW-1:1]};
          idx   <= idx + 1'b1;
          if (idx == IDX_LAST) state <= parity_on(par_mode) ? ST_PAR : ST_STOP;
        end
        ST_PAR: begin
          pbit  <= line;
          state <= ST_STOP;
        end
        ST_STOP:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] word,
  input  logic          stop_bad,
  input  logic          parity_bad,
  input  logic          rd,
  input  logic          clr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          ferr,
  output logic          perr,
  output logic          orer
);

  logic keep_old;
  logic store;

  assign keep_old = done && full && !rd;
  assign store    = done && !keep_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      orer <= 1'b0;
    end else begin
      if (store) data <= word;
      if (store)   full <= 1'b1;
      else if (rd) full <= 1'b0;
      ferr <= sticky_next(ferr, done && stop_bad,   clr);
      perr <= sticky_next(perr, done && parity_bad, clr);
      orer <= sticky_next(orer, keep_old,           clr);
    end
  end

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk #(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [1:0]        par_mode,
  input  logic              rd_strobe,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              rxd_level
);

  // Named internal events, observed by the bound checker.
  logic              line;
  logic              start_det;
  logic              busy;
  logic              mid_evt;
  logic              frame_done;
  logic              stop_bad;
  logic              parity_bad;
  logic [DATA_W-1:0] word;

  srx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line)
  );

  srx_phase #(.OVS(OVERSAMPLE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .run     (rx_en && busy),
    .restart (start_det),
    .mid_evt (mid_evt)
  );

  srx_frame #(.DW(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en),
    .tick       (tick16),
    .line       (line),
    .mid_evt    (mid_evt),
    .par_mode   (par_mode),
    .start_det  (start_det),
    .busy       (busy),
    .frame_done (frame_done),
    .stop_bad   (stop_bad),
    .parity_bad (parity_bad),
    .word       (word)
  );

  srx_status #(.DW(DATA_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (frame_done),
    .word       (word),
    .stop_bad   (stop_bad),
    .parity_bad (parity_bad),
    .rd         (rd_strobe),
    .clr        (clr_err),
    .data       (rx_data),
    .full       (rx_full),
    .ferr       (err_frame),
    .perr       (err_parity),
    .orer       (err_overrun)
  );

  assign rxd_level = line;

endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rd_strobe,
  input logic [1:0]    par_mode,
  input logic          frame_done,
  input logic          stop_bad,
  input logic          parity_bad,
  input logic          busy,
  input logic [DW-1:0] rx_data,
  input logic          rx_full,
  input logic          err_frame,
  input logic          err_parity,
  input logic          err_overrun,
  input logic          clr_err
);

  assert_done_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rx_full) |=> rx_full);

  assert_stop_low_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stop_bad) |=> err_frame);

  assert_parity_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && parity_bad) |=> err_parity);

  assert_no_parity_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (par_mode == 2'b00 || par_mode == 2'b11)) |=> $stable(err_parity) || !err_parity);

  assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=> !rx_full);

  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rd_strobe) |=> (err_overrun && $stable(rx_data)));

  assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !clr_err) |=> err_frame);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !clr_err) |=> err_overrun);

  assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy);

endmodule

bind serial_rx_brk serial_rx_brk_chk #(.DW(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .rd_strobe   (rd_strobe),
  .par_mode    (par_mode),
  .frame_done  (frame_done),
  .stop_bad    (stop_bad),
  .parity_bad  (parity_bad),
  .busy        (busy),
  .rx_data     (rx_data),
  .rx_full     (rx_full),
  .err_frame   (err_frame),
  .err_parity  (err_parity),
  .err_overrun (err_overrun),
  .clr_err     (clr_err)
);

// File: tb/serial_rx_brk_test.sv
module serial_rx_brk_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_en = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] par_mode = 2'b00;
  logic       rd_strobe = 1'b0;
  logic       clr_err = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, err_frame, err_parity, err_overrun, rxd_level;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done_run = 0;

  serial_rx_brk uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
    .par_mode(par_mode), .rd_strobe(rd_strobe), .clr_err(clr_err),
    .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .rxd_level(rxd_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick generator with adjustable spacing in clocks.
  int tick_space = 2;
  int tick_div   = 0;
  int tick_cnt   = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tick16 <= 1'b0; tick_div <= 0;
    end else if (tick_div + 1 >= tick_space) begin
      tick_div <= 0; tick16 <= 1'b1; tick_cnt <= tick_cnt + 1;
    end else begin
      tick_div <= tick_div + 1; tick16 <= 1'b0;
    end
  end

  // Behavioural reference model, stepped on every rising edge.
  bit       m_s1, m_s2, m_act, m_full, m_ferr, m_perr, m_orer;
  int       m_t;
  bit [7:0] m_byte, m_data;
  bit       m_pb;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_act = 0; m_t = 0; m_full = 0; m_data = 0;
      m_ferr = 0; m_perr = 0; m_orer = 0; m_byte = 0; m_pb = 0;
    end else begin
      bit line, fin, f_bad, p_bad, pen, ovr;
      line = m_s2; m_s2 = m_s1; m_s1 = rxd;
      fin = 0; f_bad = 0; p_bad = 0;
      pen = (par_mode == 2'b01) || (par_mode == 2'b10);
      if (!rx_en) m_act = 0;
      else if (tick16) begin
        if (!m_act) begin
          if (!line) begin m_act = 1; m_t = 0; end
        end else begin
          m_t = m_t + 1;
          if (m_t % 16 == 8) begin
            int k;
            k = m_t / 16;
            if (k == 0) begin
              if (line) m_act = 0;
            end else if (k <= 8) m_byte[k-1] = line;
            else begin
              if (pen && k == 9) m_pb = line;
              if (k == (pen ? 10 : 9)) begin
                fin = 1; m_act = 0; f_bad = !line;
                p_bad = pen && (((^m_byte) ^ m_pb) != (par_mode == 2'b10));
              end
            end
          end
        end
      end
      ovr = fin && m_full && !rd_strobe;
      if (fin && !ovr) begin m_data = m_byte; m_full = 1; end
      else if (rd_strobe) m_full = 0;
      m_ferr = (fin && f_bad) ? 1 : (clr_err ? 0 : m_ferr);
      m_perr = (fin && p_bad) ? 1 : (clr_err ? 0 : m_perr);
      m_orer = ovr ? 1 : (clr_err ? 0 : m_orer);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock comparison with the model.
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      n_checks++;
      if (rx_data !== m_data || rx_full !== m_full || err_frame !== m_ferr ||
          err_parity !== m_perr || err_overrun !== m_orer || rxd_level !== m_s2) begin
        n_fails++;
        $display("FAIL R3/R4/R5/R7/R10 model: actual %h %b%b%b%b%b expected %h %b%b%b%b%b",
                 rx_data, rx_full, err_frame, err_parity, err_overrun, rxd_level,
                 m_data, m_full, m_ferr, m_perr, m_orer, m_s2);
      end
    end
  end

  task automatic finish_run();
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done_run) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic wait_ticks(input int n);
    int t0;
    t0 = tick_cnt;
    while (tick_cnt < t0 + n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    rxd = b;
    wait_ticks(16);
  endtask

  // pmode: 0 correct parity, 1 inverted parity
  task automatic send_frame(input bit [7:0] b, input bit bad_par, input bit stop);
    send_bit(0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    if (par_mode == 2'b01) send_bit((^b) ^ bad_par);
    else if (par_mode == 2'b10) send_bit(~(^b) ^ bad_par);
    send_bit(stop);
    rxd = 1;
    wait_ticks(32);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic pulse_clr();
    clr_err = 1; @(negedge clk); clr_err = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset full", rx_full, 0);
    chk("R8 reset flags", {err_frame, err_parity, err_overrun}, 0);
    chk("R10 reset level", rxd_level, 1);
    wait_ticks(20);

    send_frame(8'hA5, 0, 1);
    chk("R3 byte A5", rx_data, 8'hA5);
    chk("R3 full set", rx_full, 1);
    chk("R4 no framing error", err_frame, 0);
    pulse_rd();
    chk("R6 read clears full", rx_full, 0);

    tick_space = 3;
    wait_ticks(4);
    send_frame(8'h5A, 0, 1);
    chk("R2 byte at spacing 3", rx_data, 8'h5A);
    pulse_rd();
    tick_space = 1;
    wait_ticks(4);
    send_frame(8'h81, 0, 1);
    chk("R2 byte at spacing 1", rx_data, 8'h81);
    pulse_rd();
    tick_space = 2;
    wait_ticks(4);

    par_mode = 2'b01;
    send_frame(8'h3C, 0, 1);
    chk("R5 even good parity", err_parity, 0);
    pulse_rd();
    send_frame(8'h3D, 1, 1);
    chk("R5 even bad parity", err_parity, 1);
    pulse_rd(); pulse_clr();
    chk("R8 clear parity", err_parity, 0);
    par_mode = 2'b10;
    send_frame(8'h07, 0, 1);
    chk("R5 odd good parity", err_parity, 0);
    chk("R5 odd data", rx_data, 8'h07);
    pulse_rd();
    send_frame(8'h07, 1, 1);
    chk("R5 odd bad parity", err_parity, 1);
    pulse_rd(); pulse_clr();
    par_mode = 2'b00;

    send_frame(8'h11, 0, 1);
    send_frame(8'h22, 0, 1);
    chk("R7 overrun set", err_overrun, 1);
    chk("R7 old byte kept", rx_data, 8'h11);
    pulse_rd();

    send_frame(8'h66, 0, 0);
    chk("R4 stop low sets framing", err_frame, 1);
    chk("R4 byte still stored", rx_data, 8'h66);
    pulse_rd();
    wait_ticks(48);
    pulse_rd();

    rx_en = 0;
    wait_ticks(40);
    chk("R8 framing kept while disabled", err_frame, 1);
    chk("R8 overrun kept while disabled", err_overrun, 1);
    pulse_clr();
    chk("R8 clear framing", err_frame, 0);
    chk("R8 clear overrun", err_overrun, 0);
    rx_en = 1;
    wait_ticks(8);

    rxd = 0; wait_ticks(4); rxd = 1;
    wait_ticks(40);
    chk("R1 short pulse gives no byte", rx_full, 0);
    chk("R1 short pulse no error", err_frame, 0);

    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    rx_en = 0;
    send_bit(1); send_bit(1);
    rxd = 1; wait_ticks(120);
    rx_en = 1;
    wait_ticks(40);
    chk("R11 partial frame discarded", rx_full, 0);

    par_mode = 2'b10;
    rxd = 0;
    wait_ticks(200);
    chk("R9 break framing", err_frame, 1);
    chk("R9 break parity under odd", err_parity, 1);
    chk("R9 break byte zero", rx_data, 0);
    chk("R10 level low in break", rxd_level, 0);
    pulse_rd(); pulse_clr();
    wait_ticks(200);
    chk("R9 framing sets again", err_frame, 1);
    rxd = 1;
    wait_ticks(64);
    chk("R10 level high after break", rxd_level, 1);
    pulse_rd(); pulse_clr();
    par_mode = 2'b00;
    wait_ticks(8);

    finish_run();
  end

endmodule